// File: doc/BRIEF.md
# Banked Working-Register and Bit-Addressable Data RAM

This block is the 128-byte internal data store of an 8-bit microcontroller core. One byte array is reached three ways: by absolute 7-bit byte address, by register name (an index R0..R7 combined with a two-bit bank select from the status word), and by single-bit address into a 16-byte bit region, where a bit write is a read-modify-write of the holding byte.

The low 32 bytes form four banks of eight working registers. The bank select picks which bank register names refer to. Every register byte also stays reachable by its absolute address whatever the bank select is. Bytes 20H..2FH hold 128 individually addressable bits and remain ordinary bytes too. Bytes 30H..7FH are plain byte storage. Reads are combinational. Writes land on the rising clock edge. Reset leaves the array untouched and only blocks writes while it is asserted.

Top module: `iram_bitbank`

## Requirements
- R1: A register-name access with bank_sel = s (bit 1 carries status-word bit 4, bit 0 carries status-word bit 3) and register index r touches byte address 8*s + r, so bank 0 is 00H..07H, bank 1 is 08H..0FH, bank 2 is 10H..17H and bank 3 is 18H..1FH.
- R2: An absolute byte access to 00H..1FH reaches the same storage whatever bank_sel holds. For example, byte 12H is R2 of bank 2.
- R3: Bit address b (0..127) maps to byte 20H + (b >> 3), bit position b[2:0], where position 0 is the least significant bit. bit_rdata shows that bit.
- R4: A bit write changes only the addressed bit. The other seven bits of its byte keep their values.
- R5: Bytes 20H..2FH are one storage seen two ways. A byte write there shows up on bit reads, and bit writes show up on byte reads.
- R6: When a byte write and a bit write hit the same byte in one cycle, the byte write's data is stored and the bit write is dropped.
- R7: When a byte write and a bit write hit different bytes in one cycle, both take effect.
- R8: Asserting or releasing reset does not change any stored byte.
- R9: While rst_n is low, byte writes and bit writes have no effect.
- R10: rd_data and bit_rdata follow their addresses combinationally. A write becomes visible only after the rising edge that captures it.
- R11: Bytes 30H..7FH store and return full bytes independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; blocks writes, keeps contents |
| bank_sel | input | 2 | Working-register bank from the status word ([1]=bit 4, [0]=bit 3) |
| wr_en | input | 1 | Byte write enable |
| wr_use_reg | input | 1 | 1: write by register name, 0: by absolute address |
| wr_addr | input | 7 | Absolute write byte address |
| wr_reg | input | 3 | Write register index R0..R7 |
| wr_data | input | 8 | Byte write data |
| rd_use_reg | input | 1 | 1: read by register name, 0: by absolute address |
| rd_addr | input | 7 | Absolute read byte address |
| rd_reg | input | 3 | Read register index R0..R7 |
| rd_data | output | 8 | Byte read data (combinational) |
| bit_addr | input | 7 | Bit address for bit read and bit write |
| bit_we | input | 1 | Bit write enable |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Addressed bit (combinational) |

## Verification
Both read results are due in the same cycle as their address, with no register in the path. The bench therefore sets an address and samples one nanosecond later without waiting for a clock. A write is due one edge after it is presented. Write tasks drive on the falling edge and sample one nanosecond after the next rising edge. The bench also reads once before that edge to confirm the old value is still held. Reset checks sample both while reset is held and after it is released, so a clear or a leaked write shows up either way.

// File: rtl/iram_pkg.sv
package iram_pkg;
    localparam int unsigned IRAM_ADDR_W = 7;
    localparam int unsigned IRAM_DATA_W = 8;
    localparam int unsigned IRAM_IDX_W  = 3;
    localparam int unsigned IRAM_BANK_W = 2;
    localparam int unsigned IRAM_BIT_BASE = 32;

    typedef enum logic {
        VIEW_ABSOLUTE = 1'b0,
        VIEW_REGNAME  = 1'b1
    } iram_view_e;
endpackage

// File: rtl/iram_addr_resolve.sv
module iram_addr_resolve #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned BANK_W = 2
) (
    input  logic              use_reg,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] byte_addr
);
    import iram_pkg::*;
    localparam int unsigned PAD_W = ADDR_W - BANK_W - IDX_W;

    logic [ADDR_W-1:0] reg_byte;
    assign reg_byte = {{PAD_W{1'b0}}, bank, reg_idx};

    always_comb begin
        unique case (iram_view_e'(use_reg))
            VIEW_REGNAME:  byte_addr = reg_byte;
            VIEW_ABSOLUTE: byte_addr = abs_addr;
            default:       byte_addr = abs_addr;
        endcase
    end
endmodule

// File: rtl/iram_bit_resolve.sv
module iram_bit_resolve #(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned BIT_BASE = 32
) (
    input  logic [ADDR_W-1:0]         bit_addr,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0] bit_pos
);
    localparam int unsigned POS_W = $clog2(DATA_W);

    assign byte_addr = ADDR_W'(BIT_BASE) + (bit_addr >> POS_W);
    assign bit_pos   = bit_addr[POS_W-1:0];
endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      byte_en,
    input  logic [ADDR_W-1:0]         byte_waddr,
    input  logic [DATA_W-1:0]         byte_wdata,
    input  logic                      bit_en,
    input  logic [ADDR_W-1:0]         bit_wbyte,
    input  logic [$clog2(DATA_W)-1:0] bit_wpos,
    input  logic                      bit_wval,
    input  logic [ADDR_W-1:0]         byte_raddr,
    output logic [DATA_W-1:0]         byte_rdata,
    input  logic [ADDR_W-1:0]         bit_rbyte,
    input  logic [$clog2(DATA_W)-1:0] bit_rpos,
    output logic                      bit_rval
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic hit_byte;
        logic hit_bit;
        assign hit_byte = byte_en && (byte_waddr == ADDR_W'(g));
        assign hit_bit  = bit_en  && (bit_wbyte  == ADDR_W'(g));

        always_ff @(posedge clk) begin
            if (hit_byte) begin
                cells[g] <= byte_wdata;
            end else if (hit_bit) begin
                cells[g][bit_wpos] <= bit_wval;
            end
        end
    end

    assign byte_rdata = cells[byte_raddr];
    assign bit_rval   = cells[bit_rbyte][bit_rpos];
endmodule

// File: rtl/iram_bitbank.sv
module iram_bitbank #(
    parameter int unsigned ADDR_W   = iram_pkg::IRAM_ADDR_W,
    parameter int unsigned DATA_W   = iram_pkg::IRAM_DATA_W,
    parameter int unsigned IDX_W    = iram_pkg::IRAM_IDX_W,
    parameter int unsigned BANK_W   = iram_pkg::IRAM_BANK_W,
    parameter int unsigned BIT_BASE = iram_pkg::IRAM_BIT_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              wr_en,
    input  logic              wr_use_reg,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [IDX_W-1:0]  wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_use_reg,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [IDX_W-1:0]  rd_reg,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_we,
    input  logic              bit_wdata,
    output logic              bit_rdata
);
    localparam int unsigned POS_W = $clog2(DATA_W);

    logic [ADDR_W-1:0] wr_byte;
    logic [ADDR_W-1:0] rd_byte;
    logic [ADDR_W-1:0] bit_byte;
    logic [POS_W-1:0]  bit_pos;
    logic              byte_go;
    logic              bit_go;

    iram_addr_resolve #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_wr_map (
        .use_reg   (wr_use_reg),
        .abs_addr  (wr_addr),
        .reg_idx   (wr_reg),
        .bank      (bank_sel),
        .byte_addr (wr_byte)
    );

    iram_addr_resolve #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_rd_map (
        .use_reg   (rd_use_reg),
        .abs_addr  (rd_addr),
        .reg_idx   (rd_reg),
        .bank      (bank_sel),
        .byte_addr (rd_byte)
    );

    iram_bit_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE)) u_bit_map (
        .bit_addr  (bit_addr),
        .byte_addr (bit_byte),
        .bit_pos   (bit_pos)
    );

    // writes are held off during reset; contents are never cleared
    assign byte_go = wr_en  && rst_n;
    assign bit_go  = bit_we && rst_n;

    iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .byte_en    (byte_go),
        .byte_waddr (wr_byte),
        .byte_wdata (wr_data),
        .bit_en     (bit_go),
        .bit_wbyte  (bit_byte),
        .bit_wpos   (bit_pos),
        .bit_wval   (bit_wdata),
        .byte_raddr (rd_byte),
        .byte_rdata (rd_data),
        .bit_rbyte  (bit_byte),
        .bit_rpos   (bit_pos),
        .bit_rval   (bit_rdata)
    );
endmodule

// File: rtl/iram_bitbank_chk.sv
module iram_bitbank_chk #(
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IDX_W    = 3,
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned BIT_BASE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BANK_W-1:0] bank_sel,
    input logic              wr_en,
    input logic              wr_use_reg,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [IDX_W-1:0]  wr_reg,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_use_reg,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] bit_addr,
    input logic              bit_we,
    input logic              bit_wdata,
    input logic              bit_rdata
);
    localparam int unsigned POS_W = $clog2(DATA_W);
    localparam int unsigned PAD_W = ADDR_W - BANK_W - IDX_W;

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    logic [ADDR_W-1:0] holder;
    logic [ADDR_W-1:0] reg_target;
    logic [DATA_W-1:0] pos_mask;
    assign holder     = ADDR_W'(BIT_BASE) + (bit_addr >> POS_W);
    assign reg_target = {{PAD_W{1'b0}}, bank_sel, wr_reg};
    assign pos_mask   = DATA_W'(1) << bit_addr[POS_W-1:0];

    p_reg_write_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n && wr_en && wr_use_reg) && !rd_use_reg && rd_addr == $past(reg_target))
        |-> rd_data == $past(wr_data));

    p_abs_write_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n && wr_en && !wr_use_reg) && !rd_use_reg && rd_addr == $past(wr_addr))
        |-> rd_data == $past(wr_data));

    p_bit_write_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n && bit_we && !wr_en) && bit_addr == $past(bit_addr))
        |-> bit_rdata == $past(bit_wdata));

    p_bit_neighbours_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n && bit_we && !wr_en && !rd_use_reg && rd_addr == holder)
         && !rd_use_reg && rd_addr == $past(rd_addr) && bit_addr == $past(bit_addr))
        |-> ((rd_data ^ $past(rd_data)) & ~pos_mask) == '0);

    p_collision_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(rst_n && bit_we && wr_en && !wr_use_reg && wr_addr == holder)
         && !rd_use_reg && rd_addr == $past(wr_addr))
        |-> rd_data == $past(wr_data));

    p_reset_hold_r9: assert property (@(posedge clk) disable iff (!armed)
        (!rst_n && $past(!rst_n) && !rd_use_reg && $past(!rd_use_reg)
         && $stable(rd_addr) && $stable(bit_addr))
        |-> ($stable(rd_data) && $stable(bit_rdata)));
endmodule

bind iram_bitbank iram_bitbank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BANK_W(BANK_W), .BIT_BASE(BIT_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_sel   (bank_sel),
    .wr_en      (wr_en),
    .wr_use_reg (wr_use_reg),
    .wr_addr    (wr_addr),
    .wr_reg     (wr_reg),
    .wr_data    (wr_data),
    .rd_use_reg (rd_use_reg),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .bit_addr   (bit_addr),
    .bit_we     (bit_we),
    .bit_wdata  (bit_wdata),
    .bit_rdata  (bit_rdata)
);

// File: tb/iram_bitbank_tb_top.sv
`timescale 1ns/1ps
module iram_bitbank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       wr_en = 1'b0;
    logic       wr_use_reg = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [2:0] wr_reg = '0;
    logic [7:0] wr_data = '0;
    logic       rd_use_reg = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [2:0] rd_reg = '0;
    logic [7:0] rd_data;
    logic [6:0] bit_addr = '0;
    logic       bit_we = 1'b0;
    logic       bit_wdata = 1'b0;
    logic       bit_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iram_bitbank dut_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_use_reg(wr_use_reg), .wr_addr(wr_addr), .wr_reg(wr_reg),
        .wr_data(wr_data), .rd_use_reg(rd_use_reg), .rd_addr(rd_addr), .rd_reg(rd_reg),
        .rd_data(rd_data), .bit_addr(bit_addr), .bit_we(bit_we), .bit_wdata(bit_wdata),
        .bit_rdata(bit_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic byte_wr(input logic use_reg, input logic [6:0] a, input logic [2:0] r,
                           input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_use_reg = use_reg; wr_addr = a; wr_reg = r; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bit_wr(input logic [6:0] b, input logic v);
        @(negedge clk);
        bit_we = 1'b1; bit_addr = b; bit_wdata = v;
        @(posedge clk); #1;
        bit_we = 1'b0;
    endtask

    task automatic rd_abs(input logic [6:0] a, output logic [7:0] d);
        rd_use_reg = 1'b0; rd_addr = a; #1; d = rd_data;
    endtask

    task automatic rd_name(input logic [2:0] r, output logic [7:0] d);
        rd_use_reg = 1'b1; rd_reg = r; #1; d = rd_data;
    endtask

    task automatic rd_bit(input logic [6:0] b, output logic v);
        bit_addr = b; #1; v = bit_rdata;
    endtask

    // R8 R9: reset keeps contents and blocks writes
    task automatic t_reset_hold();
        logic [7:0] d;
        logic v;
        byte_wr(1'b0, 7'h40, 3'd0, 8'h5A);
        byte_wr(1'b0, 7'h20, 3'd0, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        byte_wr(1'b0, 7'h40, 3'd0, 8'hFF);
        bit_wr(7'h00, 1'b1);
        rd_abs(7'h40, d); check("R9 byte write in reset", d, 8'h5A);
        rd_abs(7'h20, d); check("R9 bit write in reset", d, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        rd_abs(7'h40, d); check("R8 contents after reset", d, 8'h5A);
        rd_bit(7'h00, v); check("R8 bit after reset", {7'd0, v}, 8'h00);
    endtask

    // R1: register names map to 8*bank+index
    task automatic t_banks();
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            bank_sel = 2'(s);
            for (int r = 0; r < 8; r++) byte_wr(1'b1, 7'h0, 3'(r), 8'(8'hA0 + s * 8 + r));
        end
        for (int a = 0; a < 32; a++) begin
            rd_abs(7'(a), d); check("R1 bank byte", d, 8'(8'hA0 + a));
        end
        bank_sel = 2'd3;
        rd_name(3'd5, d); check("R1 bank3 R5 by name", d, 8'hBD);
        bank_sel = 2'd1;
        rd_name(3'd0, d); check("R1 bank1 R0 by name", d, 8'hA8);
    endtask

    // R2: absolute access ignores bank_sel
    task automatic t_absolute();
        logic [7:0] d;
        bank_sel = 2'd0;
        byte_wr(1'b0, 7'h12, 3'd0, 8'h3C);
        bank_sel = 2'd2;
        rd_name(3'd2, d); check("R2 12H is bank2 R2", d, 8'h3C);
        bank_sel = 2'd1;
        rd_abs(7'h12, d); check("R2 absolute under bank1", d, 8'h3C);
        rd_name(3'd2, d); check("R2 bank1 R2 untouched", d, 8'hAA);
    endtask

    // R3 R5: bit view of byte region
    task automatic t_bit_map();
        logic [7:0] d;
        logic v;
        byte_wr(1'b0, 7'h2B, 3'd0, 8'hA5);
        for (int i = 0; i < 8; i++) begin
            rd_bit(7'(8'h58 + i), v);
            check("R3 bit of 2BH", {7'd0, v}, {7'd0, 1'(8'hA5 >> i)});
        end
        byte_wr(1'b0, 7'h2F, 3'd0, 8'h00);
        bit_wr(7'h7F, 1'b1);
        rd_abs(7'h2F, d); check("R5 bit 7FH sets 2FH msb", d, 8'h80);
        byte_wr(1'b0, 7'h20, 3'd0, 8'h00);
        bit_wr(7'h00, 1'b1);
        rd_abs(7'h20, d); check("R3 bit 00H is 20H lsb", d, 8'h01);
    endtask

    // R4: bit write leaves neighbours
    task automatic t_bit_rmw();
        logic [7:0] d;
        byte_wr(1'b0, 7'h25, 3'd0, 8'hFF);
        bit_wr(7'h2D, 1'b0);
        rd_abs(7'h25, d); check("R4 clear bit5 of 25H", d, 8'hDF);
        byte_wr(1'b0, 7'h26, 3'd0, 8'h00);
        bit_wr(7'h32, 1'b1);
        rd_abs(7'h26, d); check("R4 set bit2 of 26H", d, 8'h04);
        rd_abs(7'h25, d); check("R4 other byte intact", d, 8'hDF);
    endtask

    // R6 R7: same-cycle byte and bit writes
    task automatic t_collide();
        logic [7:0] d;
        byte_wr(1'b0, 7'h24, 3'd0, 8'h00);
        byte_wr(1'b0, 7'h21, 3'd0, 8'h00);
        @(negedge clk);
        wr_en = 1'b1; wr_use_reg = 1'b0; wr_addr = 7'h24; wr_data = 8'h70;
        bit_we = 1'b1; bit_addr = 7'h20; bit_wdata = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; bit_we = 1'b0;
        rd_abs(7'h24, d); check("R6 byte write wins", d, 8'h70);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'h24; wr_data = 8'h11;
        bit_we = 1'b1; bit_addr = 7'h0B; bit_wdata = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; bit_we = 1'b0;
        rd_abs(7'h24, d); check("R7 byte part", d, 8'h11);
        rd_abs(7'h21, d); check("R7 bit part", d, 8'h08);
    endtask

    // R10: combinational read, write visible after the edge
    task automatic t_timing();
        logic [7:0] d;
        byte_wr(1'b0, 7'h50, 3'd0, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; wr_use_reg = 1'b0; wr_addr = 7'h50; wr_data = 8'hE7;
        rd_abs(7'h50, d); check("R10 old value before edge", d, 8'h01);
        @(posedge clk); #1;
        wr_en = 1'b0;
        rd_abs(7'h50, d); check("R10 new value after edge", d, 8'hE7);
    endtask

    // R11: general-purpose region
    task automatic t_scratch();
        logic [7:0] d;
        for (int a = 8'h30; a < 8'h80; a++) byte_wr(1'b0, 7'(a), 3'd0, 8'(a * 3 + 1));
        for (int a = 8'h30; a < 8'h80; a++) begin
            rd_abs(7'(a), d); check("R11 scratch byte", d, 8'(a * 3 + 1));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset_hold();
        t_banks();
        t_absolute();
        t_bit_map();
        t_bit_rmw();
        t_collide();
        t_timing();
        t_scratch();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule